// File: doc/BRIEF.md
# Windowed Watchdog Timer with Early Warning

This block watches system software by counting pulses of a slow timeout tick (about one per millisecond). Software keeps the chip alive by writing a fixed key to a service register before a programmable deadline. If it writes the wrong value, services too early in window mode, or misses the deadline, the block raises a reset request for one tick period and then freezes until a system reset. In normal mode an early-warning flag can be raised partway through the period so that software is warned before the deadline. The flag reaches an interrupt output only when unmasked.

The timeout period, the closed-window length and the early-warning point are each set by a 4-bit power-of-two code. The cycle count is 8 shifted left by the code. Codes above the legal maximum are clamped: 11 for the period and 10 for the window and early warning. Writes to enable, configuration and service are handed to the tick domain. A busy output stays high until the next tick has taken them in. A service attempt made while busy is refused. The configuration and the window-mode bit are locked while the watchdog is enabled.

The controller has five states. ST_IDLE means disabled. ST_CLOSED is the early part of a window-mode period, where a service is a fault. ST_OPEN is where a service is accepted. ST_FIRE drives the reset request. ST_HALT is the frozen state after a reset request.

The transitions are:
- ST_IDLE to ST_CLOSED or ST_OPEN when an enable is taken in, chosen by the window-mode bit.
- ST_CLOSED to ST_OPEN when the count reaches the window length.
- ST_CLOSED or ST_OPEN to ST_CLOSED or ST_OPEN (count restarts) on an accepted service.
- ST_CLOSED or ST_OPEN to ST_IDLE when a disable is taken in.
- ST_CLOSED or ST_OPEN to ST_FIRE on a key fault or when the count reaches the period.
- ST_FIRE to ST_HALT on the next tick.

Top module: `wdt_window`

## Requirements
- R1: After reset, rst_req, busy, ew_flag and ew_irq are low, and the block is disabled: no reset request ever follows unless it is enabled.
- R2: After an enable is taken in (wr_sel 0, bit0=1, applied at the next tick), rst_req rises exactly 8<<P ticks later. P is the period code in bits [3:0] of wr_sel 1.
- R3: rst_req stays high until the next tick, then stays low until system reset. Service writes in that frozen state have no effect.
- R4: Writing 0xA5 to wr_sel 6 in the open window, while not busy, restarts the count at the next tick. The timeout then falls 8<<P ticks after that tick.
- R5: Writing any value other than 0xA5 to wr_sel 6 while enabled and not busy raises rst_req on the next clock.
- R6: Window mode (wr_sel 0 bit1) keeps a closed window of 8<<W ticks after each start or service. W is bits [7:4] of wr_sel 1. A 0xA5 write inside the closed window raises rst_req on the next clock. A write after it is accepted and starts a new closed window.
- R7: An accepted write to wr_sel 0, wr_sel 1 or wr_sel 6 sets busy on the next clock until a tick takes it in. A service write while busy is refused: no reset and no effect.
- R8: While enabled, writes to wr_sel 1 and to the window-mode bit are ignored and do not set busy.
- R9: In normal mode ew_flag rises exactly 8<<E ticks after a start or service. E is bits [3:0] of wr_sel 2. In window mode ew_flag never rises.
- R10: ew_irq equals ew_flag AND the mask bit. Writing bit0=1 to wr_sel 3 sets the mask bit, and to wr_sel 4 clears it. Writing bit0=1 to wr_sel 5 clears ew_flag.
- R11: A disable (wr_sel 0, bit0=0) taken in at a tick stops counting: no reset request follows. Service writes while disabled are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low system reset |
| tick | input | 1 | One-clock pulse per timeout-clock period |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select (0 ctrl, 1 cfg, 2 early-warning code, 3 mask set, 4 mask clear, 5 flag clear, 6 service) |
| wr_data | input | 8 | Write data |
| busy | output | 1 | A write is waiting for the tick domain |
| ew_flag | output | 1 | Early-warning flag |
| ew_irq | output | 1 | Masked early-warning interrupt |
| rst_req | output | 1 | Reset request pulse |

## Verification
A table of period and early-warning codes exercises the power-of-two decode. Adjacent codes and an early-warning code two steps below the period separate a correct shift from an off-by-one or a fixed offset. Service writes are tried with the key and without it, inside and outside the closed window, and while busy, which separates the fault, refuse and restart paths. Configuration and window-bit writes issued after enabling show whether the lock holds, because the timeout length and the window behaviour would change if it did not.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int SEL_W  = 3;
    localparam int DATA_W = 8;
    localparam int CODE_W = 4;

    localparam logic [SEL_W-1:0] SEL_CTRL  = 3'd0;
    localparam logic [SEL_W-1:0] SEL_CFG   = 3'd1;
    localparam logic [SEL_W-1:0] SEL_EWOFS = 3'd2;
    localparam logic [SEL_W-1:0] SEL_IESET = 3'd3;
    localparam logic [SEL_W-1:0] SEL_IECLR = 3'd4;
    localparam logic [SEL_W-1:0] SEL_FLAG  = 3'd5;
    localparam logic [SEL_W-1:0] SEL_SVC   = 3'd6;

    localparam logic [DATA_W-1:0] SVC_KEY = 8'hA5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLOSED,
        ST_OPEN,
        ST_FIRE,
        ST_HALT
    } wdt_state_e;
endpackage

// File: rtl/wdt_code2cyc.sv
module wdt_code2cyc
    import wdt_pkg::*;
#(
    parameter int BASE_LOG2 = 3,
    parameter int MAX_CODE  = 11,
    parameter int CNT_W     = 15
) (
    input  logic [CODE_W-1:0] code,
    output logic [CNT_W-1:0]  cycles
);
    localparam int SH_W = $clog2(CNT_W);

    logic [CODE_W-1:0] eff;
    logic [SH_W-1:0]   sh;

    always_comb begin
        eff    = (code > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : code;
        sh     = SH_W'(BASE_LOG2) + SH_W'(eff);
        cycles = {{(CNT_W-1){1'b0}}, 1'b1} << sh;
    end
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              armed,
    input  logic              in_closed,
    input  logic              ew_hit,
    output logic              wen_q,
    output logic [CODE_W-1:0] per_code,
    output logic [CODE_W-1:0] win_code,
    output logic [CODE_W-1:0] ew_code,
    output logic              en_go,
    output logic              en_stop,
    output logic              svc_go,
    output logic              key_fault,
    output logic              busy,
    output logic              ew_flag,
    output logic              ew_irq
);
    logic en_q;
    logic pend_ctrl, pend_en, pend_cfg, pend_svc;
    logic ie_q;
    logic wr_ctrl, wr_cfg, wr_ewofs, wr_ieset, wr_ieclr, wr_flag;
    logic svc_try, svc_ok;

    always_comb begin
        wr_ctrl   = wr_en && (wr_sel == SEL_CTRL);
        wr_cfg    = wr_en && (wr_sel == SEL_CFG) && !en_q;
        wr_ewofs  = wr_en && (wr_sel == SEL_EWOFS);
        wr_ieset  = wr_en && (wr_sel == SEL_IESET) && wr_data[0];
        wr_ieclr  = wr_en && (wr_sel == SEL_IECLR) && wr_data[0];
        wr_flag   = wr_en && (wr_sel == SEL_FLAG) && wr_data[0];
        busy      = pend_ctrl | pend_cfg | pend_svc;
        svc_try   = wr_en && (wr_sel == SEL_SVC) && armed && !busy;
        key_fault = svc_try && ((wr_data != SVC_KEY) || in_closed);
        svc_ok    = svc_try && !key_fault;
        en_go     = tick && pend_ctrl && pend_en;
        en_stop   = tick && pend_ctrl && !pend_en;
        svc_go    = tick && pend_svc;
        ew_irq    = ew_flag & ie_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q      <= 1'b0;
            wen_q     <= 1'b0;
            pend_ctrl <= 1'b0;
            pend_en   <= 1'b0;
            pend_cfg  <= 1'b0;
            pend_svc  <= 1'b0;
            per_code  <= '0;
            win_code  <= '0;
            ew_code   <= '0;
        end else begin
            if (tick) begin
                pend_ctrl <= 1'b0;
                pend_cfg  <= 1'b0;
                pend_svc  <= 1'b0;
                if (pend_ctrl) en_q <= pend_en;
            end
            if (wr_ctrl) begin
                pend_ctrl <= 1'b1;
                pend_en   <= wr_data[0];
                if (!en_q) wen_q <= wr_data[1];
            end
            if (wr_cfg) begin
                pend_cfg <= 1'b1;
                per_code <= wr_data[CODE_W-1:0];
                win_code <= wr_data[2*CODE_W-1:CODE_W];
            end
            if (wr_ewofs) ew_code <= wr_data[CODE_W-1:0];
            if (svc_ok)   pend_svc <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie_q    <= 1'b0;
            ew_flag <= 1'b0;
        end else begin
            if (wr_ieset)      ie_q <= 1'b1;
            else if (wr_ieclr) ie_q <= 1'b0;
            if (ew_hit)        ew_flag <= 1'b1;
            else if (wr_flag)  ew_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/wdt_fsm.sv
module wdt_fsm
    import wdt_pkg::*;
#(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             en_go,
    input  logic             en_stop,
    input  logic             svc_go,
    input  logic             key_fault,
    input  logic             wen,
    input  logic [CNT_W-1:0] per_cyc,
    input  logic [CNT_W-1:0] win_cyc,
    input  logic [CNT_W-1:0] ew_cyc,
    output logic             armed,
    output logic             in_closed,
    output logic             rst_req,
    output logic             ew_hit
);
    wdt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        cnt_inc = cnt_q + 1'b1;
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (en_go) begin
                    state_d = wen ? ST_CLOSED : ST_OPEN;
                    cnt_d   = '0;
                end
            end
            ST_CLOSED, ST_OPEN: begin
                if (key_fault) begin
                    state_d = ST_FIRE;
                end else if (tick) begin
                    if (en_stop) begin
                        state_d = ST_IDLE;
                        cnt_d   = '0;
                    end else if (svc_go) begin
                        state_d = wen ? ST_CLOSED : ST_OPEN;
                        cnt_d   = '0;
                    end else if (cnt_inc == per_cyc) begin
                        state_d = ST_FIRE;
                    end else begin
                        cnt_d = cnt_inc;
                        if (state_q == ST_CLOSED && cnt_inc == win_cyc)
                            state_d = ST_OPEN;
                    end
                end
            end
            ST_FIRE: begin
                if (tick) state_d = ST_HALT;
            end
            ST_HALT: begin
                state_d = ST_HALT;
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        armed     = (state_q == ST_CLOSED) || (state_q == ST_OPEN);
        in_closed = (state_q == ST_CLOSED);
        rst_req   = (state_q == ST_FIRE);
        ew_hit    = tick && (state_q == ST_OPEN) && !wen && !key_fault
                    && !en_stop && !svc_go && (cnt_inc == ew_cyc);
    end
endmodule

// File: rtl/wdt_window.sv
module wdt_window
    import wdt_pkg::*;
#(
    parameter int BASE_LOG2    = 3,
    parameter int MAX_PER_CODE = 11,
    parameter int MAX_WIN_CODE = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic              busy,
    output logic              ew_flag,
    output logic              ew_irq,
    output logic              rst_req
);
    localparam int CNT_W = BASE_LOG2 + MAX_PER_CODE + 1;
    localparam int N_DEC = 3;

    logic              wen_w, en_go_w, en_stop_w, svc_go_w, key_fault_w;
    logic              armed_w, in_closed_w, ew_hit_w;
    logic [CODE_W-1:0] per_code_w, win_code_w, ew_code_w;
    logic [CODE_W-1:0] code_v [N_DEC];
    logic [CNT_W-1:0]  cyc_v  [N_DEC];

    assign code_v[0] = per_code_w;
    assign code_v[1] = win_code_w;
    assign code_v[2] = ew_code_w;

    wdt_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .armed     (armed_w),
        .in_closed (in_closed_w),
        .ew_hit    (ew_hit_w),
        .wen_q     (wen_w),
        .per_code  (per_code_w),
        .win_code  (win_code_w),
        .ew_code   (ew_code_w),
        .en_go     (en_go_w),
        .en_stop   (en_stop_w),
        .svc_go    (svc_go_w),
        .key_fault (key_fault_w),
        .busy      (busy),
        .ew_flag   (ew_flag),
        .ew_irq    (ew_irq)
    );

    for (genvar g = 0; g < N_DEC; g++) begin : g_dec
        localparam int LIM = (g == 0) ? MAX_PER_CODE : MAX_WIN_CODE;
        wdt_code2cyc #(
            .BASE_LOG2 (BASE_LOG2),
            .MAX_CODE  (LIM),
            .CNT_W     (CNT_W)
        ) u_dec (
            .code   (code_v[g]),
            .cycles (cyc_v[g])
        );
    end

    wdt_fsm #(
        .CNT_W (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .en_go     (en_go_w),
        .en_stop   (en_stop_w),
        .svc_go    (svc_go_w),
        .key_fault (key_fault_w),
        .wen       (wen_w),
        .per_cyc   (cyc_v[0]),
        .win_cyc   (cyc_v[1]),
        .ew_cyc    (cyc_v[2]),
        .armed     (armed_w),
        .in_closed (in_closed_w),
        .rst_req   (rst_req),
        .ew_hit    (ew_hit_w)
    );
endmodule

// File: rtl/wdt_window_chk.sv
module wdt_window_chk
    import wdt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              wr_en,
    input logic [SEL_W-1:0]  wr_sel,
    input logic [DATA_W-1:0] wr_data,
    input logic              busy,
    input logic              ew_flag,
    input logic              ew_irq,
    input logic              rst_req,
    input logic              armed
);
    logic fired_done;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 fired_done <= 1'b0;
        else if (rst_req == 1'b0 && $past(rst_req)) fired_done <= 1'b1;
    end

    assert_rst_ends_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_req) |-> $past(tick));

    assert_no_second_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fired_done |-> !rst_req);

    assert_bad_key_fires_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_SVC && wr_data != SVC_KEY && !busy && armed) |=> rst_req);

    assert_busy_clears_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(tick));

    assert_flag_sets_on_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ew_flag) |-> $past(tick));

    assert_irq_needs_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ew_irq |-> ew_flag);
endmodule

bind wdt_window wdt_window_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .busy    (busy),
    .ew_flag (ew_flag),
    .ew_irq  (ew_irq),
    .rst_req (rst_req),
    .armed   (armed_w)
);

// File: tb/wdt_window_tb.sv
`timescale 1ns/1ps
module wdt_window_tb;
    localparam int TICK_DIV = 4;
    localparam int WD_CYC   = 150000;
    localparam int WAIT_LIM = 40000;
    localparam logic [2:0] A_CTRL = 3'd0, A_CFG = 3'd1, A_EW = 3'd2, A_ISET = 3'd3,
                           A_ICLR = 3'd4, A_FLAG = 3'd5, A_SVC = 3'd6;
    // per code, early-warning code, expected ew ticks, expected timeout ticks
    localparam int VEC [4][4] = '{'{1, 0, 8, 16}, '{2, 1, 16, 32},
                                   '{3, 2, 32, 64}, '{2, 0, 8, 32}};

    logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
    logic [2:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic       busy, ew_flag, ew_irq, rst_req;
    int         checks = 0, failures = 0, tick_count = 0;

    wdt_window u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .busy(busy), .ew_flag(ew_flag), .ew_irq(ew_irq),
        .rst_req(rst_req)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) if (tick) tick_count <= tick_count + 1;

    initial begin
        int divc = 0;
        forever begin
            @(negedge clk);
            divc++;
            tick = (divc % TICK_DIV) == 0;
        end
    end

    initial begin
        repeat (WD_CYC) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        wr_en = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < WAIT_LIM && busy; i++) @(negedge clk);
    endtask

    task automatic wait_until(input int t);
        for (int i = 0; i < WAIT_LIM && tick_count < t; i++) @(negedge clk);
    endtask

    // returns number of ticks from t0 until rst_req, -1 if never within n ticks
    task automatic watch_rst(input int t0, input int n, output int el);
        el = -1;
        for (int i = 0; i < WAIT_LIM && tick_count <= t0 + n; i++) begin
            if (rst_req) begin el = tick_count - t0; break; end
            @(negedge clk);
        end
    endtask

    initial begin
        int t0, t1, el, ew_at;
        do_reset();

        // R1 reset state
        chk("R1 rst_req", rst_req, 0);
        chk("R1 busy", busy, 0);
        chk("R1 ew_flag", ew_flag, 0);
        chk("R1 ew_irq", ew_irq, 0);
        watch_rst(tick_count, 40, el);
        chk("R1 disabled no reset", el, -1);

        // R2 / R9 table of codes
        for (int v = 0; v < 4; v++) begin
            do_reset();
            wr(A_CFG, 8'(VEC[v][0]));
            wr(A_EW, 8'(VEC[v][1]));
            wr(A_CTRL, 8'h01);
            wait_idle();
            t0 = tick_count; ew_at = -1; el = -1;
            for (int i = 0; i < WAIT_LIM; i++) begin
                if (ew_flag && ew_at < 0) ew_at = tick_count - t0;
                if (rst_req) begin el = tick_count - t0; break; end
                @(negedge clk);
            end
            chk($sformatf("R9 ew ticks vec%0d", v), ew_at, VEC[v][2]);
            chk($sformatf("R2 timeout ticks vec%0d", v), el, VEC[v][3]);
        end

        // R7 busy and refusal, R4 restart, R3 pulse and freeze
        do_reset();
        wr(A_CFG, 8'h00);
        chk("R7 busy after cfg", busy, 1);
        wait_idle();
        wr(A_CTRL, 8'h01);
        chk("R7 busy after ctrl", busy, 1);
        wait_idle();
        t0 = tick_count;
        wait_until(t0 + 3);
        wr(A_SVC, 8'hA5);
        chk("R7 busy after service", busy, 1);
        wr(A_SVC, 8'h00);
        chk("R7 refused while busy", rst_req, 0);
        wait_idle();
        t1 = tick_count;
        watch_rst(t1, 20, el);
        chk("R4 restart timeout", el, 8);
        t0 = tick_count;
        for (int i = 0; i < WAIT_LIM && rst_req; i++) @(negedge clk);
        chk("R3 pulse one tick", tick_count - t0, 1);
        wr(A_SVC, 8'h00);
        watch_rst(tick_count, 30, el);
        chk("R3 frozen no reset", el, -1);

        // R5 wrong key
        do_reset();
        wr(A_CFG, 8'h03);
        wr(A_CTRL, 8'h01);
        wait_idle();
        wait_until(tick_count + 2);
        wr(A_SVC, 8'h5A);
        chk("R5 wrong key resets", rst_req, 1);

        // R6 window mode: closed then open
        do_reset();
        wr(A_CFG, 8'h12);
        wr(A_CTRL, 8'h03);
        wait_idle();
        wait_until(tick_count + 5);
        wr(A_SVC, 8'hA5);
        chk("R6 closed window service resets", rst_req, 1);
        do_reset();
        wr(A_CFG, 8'h12);
        wr(A_CTRL, 8'h03);
        wait_idle();
        t0 = tick_count;
        wait_until(t0 + 18);
        chk("R9 no flag in window mode", ew_flag, 0);
        wr(A_SVC, 8'hA5);
        chk("R6 open window accepted", rst_req, 0);
        wait_idle();
        wait_until(tick_count + 4);
        wr(A_SVC, 8'hA5);
        chk("R6 closed window restarts", rst_req, 1);

        // R8 configuration lock
        do_reset();
        wr(A_CFG, 8'h00);
        wr(A_CTRL, 8'h01);
        wait_idle();
        wr(A_CFG, 8'h03);
        chk("R8 locked cfg no busy", busy, 0);
        wr(A_CTRL, 8'h03);
        wait_idle();
        wr(A_SVC, 8'hA5);
        chk("R8 window bit locked", rst_req, 0);
        wait_idle();
        t1 = tick_count;
        watch_rst(t1, 80, el);
        chk("R8 period unchanged", el, 8);

        // R10 interrupt masking
        do_reset();
        wr(A_CFG, 8'h02);
        wr(A_EW, 8'h01);
        wr(A_CTRL, 8'h01);
        wait_idle();
        for (int i = 0; i < WAIT_LIM && !ew_flag; i++) @(negedge clk);
        chk("R10 flag set", ew_flag, 1);
        chk("R10 masked irq", ew_irq, 0);
        wr(A_ISET, 8'h01);
        chk("R10 irq unmasked", ew_irq, 1);
        wr(A_ICLR, 8'h01);
        chk("R10 irq masked again", ew_irq, 0);
        wr(A_ISET, 8'h01);
        wr(A_FLAG, 8'h01);
        chk("R10 flag cleared", ew_flag, 0);
        chk("R10 irq after clear", ew_irq, 0);

        // R11 disable
        do_reset();
        wr(A_CFG, 8'h00);
        wr(A_CTRL, 8'h01);
        wait_idle();
        wait_until(tick_count + 2);
        wr(A_CTRL, 8'h00);
        wait_idle();
        watch_rst(tick_count, 30, el);
        chk("R11 disabled no timeout", el, -1);
        wr(A_SVC, 8'h5A);
        chk("R11 service ignored", rst_req, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule